// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This peripheral watches a bank of digital inputs and raises a single level interrupt when selected inputs change state. All inputs can be read at any time as a plain input word. Only the low group of channels (16 by default) can generate interrupts. Two per-channel masks, called rise/high and fall/low, are shared by the two combining modes. In edge mode, a rising edge on any channel selected by the rise/high mask fires, and so does a falling edge on any channel selected by the fall/low mask. In level mode, the interrupt fires only when every channel selected by the rise/high mask is high and every channel selected by the fall/low mask is low, all at the same time.

When the interrupt fires, the block takes a snapshot of the interruptible inputs. Software reads that snapshot from the status register, and the read acknowledges the event. The sequencer has three states:
- WATCH: looking for a trigger.
- PEND: an event is latched.
- BLOCK: a level-mode condition has been consumed and must be released before it can fire again.

Its transitions are:
- WATCH→PEND on a trigger while enabled.
- PEND→WATCH on a status read once the level condition has been released, or at any time in edge mode.
- PEND→BLOCK on a status read while the level condition is still unreleased.
- BLOCK→WATCH once the level condition goes false or edge mode is selected.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Reading the input word (byte offset 0x00) returns the full input bus, two clock edges after an input settles.
- R2: Mask registers rise/high (0x04) and fall/low (0x08) read back as written, all 32 bits. The control register (0x10) keeps only bit 1 (mode: 0 edge, 1 level) and bit 2 (enable), and reads zero elsewhere.
- R3: In edge mode, a rising edge on a channel set in the rise/high mask raises `irq`.
- R4: In edge mode, a falling edge on a channel set in the fall/low mask raises `irq`, and a rising edge on that channel does not.
- R5: Channels at or above the interruptible count never raise `irq`, whatever their mask bits hold.
- R6: In level mode, `irq` rises only when all selected channels meet their levels together. A partial match does not raise it.
- R7: After a level-mode event, the held condition does not fire again. A change on an unselected channel does not release it. A selected channel leaving its level re-arms the trigger.
- R8: Reading status (0x0C) returns the captured interruptible inputs in bits 15:0 and clears the pending event, so `irq` is low in the next cycle.
- R9: `irq` equals pending AND enable. Clearing enable drops `irq`, and setting it again with the event still pending restores `irq`.
- R10: After reset, all registers read zero and `irq` is low.
- R11: Triggers that occur while enable is clear are not latched, and do not appear after enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| din | input | 32 | Asynchronous digital inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read acknowledges) |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit input bus, 16 interruptible channels and a two-stage synchroniser. These values put upper channels in reach that have mask storage but no trigger path, which is how the exclusion of high channels is shown. They also keep the input-to-interrupt delay at a fixed three edges, so the timing of each snapshot and each acknowledge can be predicted exactly.

// File: rtl/cos_pkg.sv
package cos_pkg;
    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_PEND  = 2'd1,
        ST_BLOCK = 2'd2
    } cos_state_t;

    localparam int OFS_DATA = 'h00;
    localparam int OFS_RMSK = 'h04;
    localparam int OFS_FMSK = 'h08;
    localparam int OFS_STAT = 'h0C;
    localparam int OFS_CTRL = 'h10;

    localparam int CTL_MODE_BIT = 1;
    localparam int CTL_EN_BIT   = 2;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[k] <= '0;
            else        stg[k] <= stg[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= stg[STAGES-1];
    end

    assign cur = stg[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
    parameter int NI = 16
) (
    input  logic [NI-1:0] cur,
    input  logic [NI-1:0] prev,
    input  logic [NI-1:0] rmsk,
    input  logic [NI-1:0] fmsk,
    input  logic          level_mode,
    output logic          fire,
    output logic          cond
);
    logic [NI-1:0] edge_hit;
    logic [NI-1:0] lvl_ok;
    logic [NI-1:0] sel;

    for (genvar i = 0; i < NI; i++) begin : g_ch
        assign edge_hit[i] = (rmsk[i] & cur[i] & ~prev[i]) |
                             (fmsk[i] & ~cur[i] & prev[i]);
        assign lvl_ok[i]   = (~rmsk[i] | cur[i]) & (~fmsk[i] | ~cur[i]);
        assign sel[i]      = rmsk[i] | fmsk[i];
    end

    always_comb begin
        cond = (|sel) & (&lvl_ok);
        fire = level_mode ? cond : (|edge_hit);
    end
endmodule

// File: rtl/cos_fsm.sv
module cos_fsm
    import cos_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       level_mode,
    input  logic       fire,
    input  logic       cond,
    input  logic       clr,
    output cos_state_t state,
    output logic       capture,
    output logic       pend
);
    cos_state_t nxt;
    logic       released_q;
    logic       released_d;

    always_comb begin
        nxt        = state;
        released_d = released_q;
        unique case (state)
            ST_WATCH: begin
                if (en && fire) begin
                    nxt        = ST_PEND;
                    released_d = 1'b0;
                end
            end
            ST_PEND: begin
                if (!level_mode || !cond) released_d = 1'b1;
                if (clr) begin
                    if (!level_mode || !cond || released_q) nxt = ST_WATCH;
                    else                                     nxt = ST_BLOCK;
                end
            end
            ST_BLOCK: begin
                if (!level_mode || !cond) nxt = ST_WATCH;
            end
            default: nxt = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_WATCH;
            released_q <= 1'b0;
        end else begin
            state      <= nxt;
            released_q <= released_d;
        end
    end

    always_comb begin
        capture = (state == ST_WATCH) && en && fire;
        pend    = (state == ST_PEND);
    end

    // R3
    take_to_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH && en && fire) |=> (state == ST_PEND));

    // R7
    block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLOCK && level_mode && cond) |=> (state != ST_PEND));

    // R8
    clr_leaves_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND && clr) |=> (state != ST_PEND));
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int NW     = 32,
    parameter int NI     = 16,
    parameter int STAGES = 2,
    parameter int AW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] din,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [NW-1:0] wdata,
    output logic [NW-1:0] rdata,
    output logic          irq
);
    localparam int PADW = NW - NI;

    logic [NW-1:0] cur, prev;
    logic [NW-1:0] rmsk_q, fmsk_q;
    logic          ctl_en, ctl_mode;
    logic [NI-1:0] snap_q;
    logic          fire, cond, capture, pend, clr;
    cos_state_t    state;

    cos_sync #(.W(NW), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(din), .cur(cur), .prev(prev)
    );

    cos_detect #(.NI(NI)) u_det (
        .cur(cur[NI-1:0]), .prev(prev[NI-1:0]),
        .rmsk(rmsk_q[NI-1:0]), .fmsk(fmsk_q[NI-1:0]),
        .level_mode(ctl_mode), .fire(fire), .cond(cond)
    );

    cos_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .level_mode(ctl_mode),
        .fire(fire), .cond(cond), .clr(clr),
        .state(state), .capture(capture), .pend(pend)
    );

    assign clr = rd_en && (int'(addr) == OFS_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rmsk_q   <= '0;
            fmsk_q   <= '0;
            ctl_en   <= 1'b0;
            ctl_mode <= 1'b0;
        end else if (wr_en) begin
            if (int'(addr) == OFS_RMSK) rmsk_q <= wdata;
            if (int'(addr) == OFS_FMSK) fmsk_q <= wdata;
            if (int'(addr) == OFS_CTRL) begin
                ctl_en   <= wdata[CTL_EN_BIT];
                ctl_mode <= wdata[CTL_MODE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= cur[NI-1:0];
    end

    always_comb begin
        rdata = '0;
        unique case (int'(addr))
            OFS_DATA: rdata = cur;
            OFS_RMSK: rdata = rmsk_q;
            OFS_FMSK: rdata = fmsk_q;
            OFS_STAT: rdata = {{PADW{1'b0}}, snap_q};
            OFS_CTRL: begin
                rdata[CTL_EN_BIT]   = ctl_en;
                rdata[CTL_MODE_BIT] = ctl_mode;
            end
            default:  rdata = '0;
        endcase
    end

    assign irq = pend && ctl_en;

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !irq);

    // R6
    and_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && ctl_mode) |=>
            (((snap_q & $past(rmsk_q[NI-1:0])) == $past(rmsk_q[NI-1:0])) &&
             ((~snap_q & $past(fmsk_q[NI-1:0])) == $past(fmsk_q[NI-1:0]))));
endmodule

// File: tb/test_cos_irq_ctrl.sv
`timescale 1ns/1ps
module test_cos_irq_ctrl;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    event smp;

    always #(TCK/2) clk = ~clk;

    cos_irq_ctrl i_cos_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: pops expected read data as each read is sampled
    initial begin
        forever begin
            @(smp);
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard: read without expectation, act=%h exp=none", rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (rdata !== e.val) begin
                    bad++;
                    $display("FAIL %s: rdata act=%h exp=%h", e.tag, rdata, e.val);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.val = exp; e.tag = tag;
        sb_q.push_back(e);
        addr = a; rd_en = 1'b1;
        #(TCK/4);
        -> smp;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s: irq act=%b exp=%b", tag, irq, exp);
        end
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        chk_irq(1'b0, "R10");
        rd_expect(5'h00, 32'h0, "R10 data");
        rd_expect(5'h04, 32'h0, "R10 rise mask");
        rd_expect(5'h10, 32'h0, "R10 ctrl");

        // R1 input word after sync
        din = 32'hA5A5_3C3C;
        step(3);
        rd_expect(5'h00, 32'hA5A5_3C3C, "R1");

        // R2 readback
        wr(5'h04, 32'hDEAD_BEEF);
        wr(5'h08, 32'h1234_5678);
        rd_expect(5'h04, 32'hDEAD_BEEF, "R2 rise mask");
        rd_expect(5'h08, 32'h1234_5678, "R2 fall mask");
        wr(5'h10, 32'hFFFF_FFFF);
        rd_expect(5'h10, 32'h0000_0006, "R2 ctrl");
        wr(5'h10, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h0);

        // R3 edge mode rising
        din = 32'h0; step(4);
        wr(5'h04, 32'h1);
        wr(5'h10, 32'h4);
        step(2);
        chk_irq(1'b0, "R3 quiet");
        din = 32'h1; step(4);
        chk_irq(1'b1, "R3");
        rd_expect(5'h0C, 32'h0000_0001, "R8 edge snapshot");
        chk_irq(1'b0, "R8 cleared");

        // R4 falling-only channel
        wr(5'h08, 32'h2);
        din = 32'h3; step(4);
        chk_irq(1'b0, "R4 rise ignored");
        din = 32'h1; step(4);
        chk_irq(1'b1, "R4");
        rd_expect(5'h0C, 32'h0000_0001, "R8 fall snapshot");
        chk_irq(1'b0, "R8 cleared");

        // R5 high channels never fire
        wr(5'h04, 32'hFFFF_0000);
        wr(5'h08, 32'hFFFF_0000);
        din = 32'h5551_0001; step(4);
        chk_irq(1'b0, "R5 rise");
        din = 32'h0000_0001; step(4);
        chk_irq(1'b0, "R5 fall");

        // R11 disabled triggers not latched
        wr(5'h10, 32'h0);
        wr(5'h04, 32'h1);
        wr(5'h08, 32'h0);
        din = 32'h0; step(4);
        din = 32'h1; step(4);
        chk_irq(1'b0, "R11 disabled");
        wr(5'h10, 32'h4);
        step(4);
        chk_irq(1'b0, "R11 after enable");

        // R9 enable gating
        wr(5'h08, 32'h1);
        din = 32'h0; step(4);
        chk_irq(1'b1, "R9 event");
        wr(5'h10, 32'h0);
        chk_irq(1'b0, "R9 disabled");
        wr(5'h10, 32'h4);
        chk_irq(1'b1, "R9 restored");
        rd_expect(5'h0C, 32'h0000_0000, "R8 snapshot");
        chk_irq(1'b0, "R8 cleared");

        // R6 level mode
        wr(5'h10, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h0);
        din = 32'h0; step(4);
        wr(5'h04, 32'h5);
        wr(5'h08, 32'h2);
        wr(5'h10, 32'h6);
        din = 32'h1; step(4);
        chk_irq(1'b0, "R6 partial");
        din = 32'h7; step(4);
        chk_irq(1'b0, "R6 low violated");
        din = 32'hFFFF_0005; step(4);
        chk_irq(1'b1, "R6 all met");
        rd_expect(5'h0C, 32'h0000_0005, "R8 level snapshot");
        chk_irq(1'b0, "R8 cleared");

        // R7 no refire, unselected change, rearm
        step(6);
        chk_irq(1'b0, "R7 held");
        din = 32'hFFFF_000D; step(4);
        chk_irq(1'b0, "R7 unselected change");
        din = 32'h0000_000C; step(4);
        chk_irq(1'b0, "R7 released");
        din = 32'h0000_000D; step(4);
        chk_irq(1'b1, "R7 rearmed");
        rd_expect(5'h0C, 32'h0000_000D, "R7 snapshot");

        // R10 back to idle
        wr(5'h10, 32'h0);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'h0);
        step(2);
        chk_irq(1'b0, "R10 idle");
        rd_expect(5'h10, 32'h0, "R10 idle ctrl");

        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule